// File: doc/BRIEF.md
# Register Write-Pending Hazard Scoreboard

This block keeps one bit per architectural register. A bit is high while some instruction that has already been issued still owes a result to that register. Function units report three kinds of event to the block. An issue that names a destination sets the bit for that register. A granted register-file write port clears the bit for the register it writes. A unit that completes without producing its result also clears the bit for the destination it latched at issue.

Two kinds of check run against the stored vector. A read-after-write check takes the source registers of a unit and flags any of them that still has a write pending. A write-after-write check takes the destination of the unit now being picked and flags it if that register is still awaiting an older write. Both checks see the registered vector, so a set made by an instruction in the cycle it issues is not visible to that same instruction.

A parameter picks how register selects are encoded. They are either binary indices or one-hot masks that are used directly as masks. Instruction decode, register storage and port arbitration sit outside the block.

Top module: `hazard_scoreboard`

## Requirements
- R1: After reset every pending bit is zero, and neither hazard output is high.
- R2: A pending bit becomes one in the cycle after `issue_i`, `pick_i` and `wflag_i` of a unit are all high with `dst_sel_i` naming that register. If any one of the three is low, nothing is set.
- R3: In the cycle an instruction issues, `waw_hzd_o` does not report that instruction's own set. The set shows in the next cycle.
- R4: When `wgnt_i` of a unit is high, the register named by its `wsel_i` is clear in the next cycle, unless it is set in the same cycle.
- R5: Consider a unit that issued with `wflag_i` high and is still busy. If it raises `done_i` while `wok_i` is low, the destination latched at issue is cleared in the next cycle. If `wok_i` is high, `done_i` clears nothing.
- R6: The latched write flag drops in any cycle in which the unit is not busy and does not issue. A later `done_i` with `wok_i` low then clears nothing.
- R7: If a set and a clear hit the same bit in the same cycle, the bit ends up one.
- R8: Sets from several units are OR-combined in one cycle, and so are clears from several units.
- R9: `raw_unit_o[u]` is high when `pick_i[u]` is high and some source with `src_vld_i` high names a pending register. `raw_hzd_o` is the OR of all units. A source with its valid bit low is ignored.
- R10: Take a cycle in which a unit's `busy_i` is high and its read check reports nothing. From the next cycle on, that unit's source checks report nothing until a cycle with `busy_i` low has passed.
- R11: `waw_hzd_o` is high when some unit has `pick_i` and `wflag_i` high and its `dst_sel_i` names a pending register.
- R12: With `SEL_ENC` at binary (the default), a select is a register index of $clog2(NUM_REGS) bits. With it at one-hot, a select is an NUM_REGS-bit mask that is applied as is, so it may name several registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_i | input | NUM_UNITS | Unit issues this cycle |
| pick_i | input | NUM_UNITS | Unit is picked or active |
| wflag_i | input | NUM_UNITS | Instruction writes a destination |
| busy_i | input | NUM_UNITS | Unit is busy |
| done_i | input | NUM_UNITS | Unit completes |
| wok_i | input | NUM_UNITS | Unit's result is valid for writing |
| wgnt_i | input | NUM_UNITS | Unit's write port grant |
| dst_sel_i | input | NUM_UNITS x SEL_W | Destination select |
| wsel_i | input | NUM_UNITS x SEL_W | Granted write port register select |
| src_vld_i | input | NUM_UNITS x NUM_SRC | Source operand is read |
| src_sel_i | input | NUM_UNITS x NUM_SRC x SEL_W | Source register selects |
| pend_o | output | NUM_REGS | Pending-write vector |
| raw_unit_o | output | NUM_UNITS | Read-after-write hazard for each unit |
| raw_hzd_o | output | 1 | Any read-after-write hazard |
| waw_hzd_o | output | 1 | Any write-after-write hazard |

## Verification
An issue that sets a bit and a write grant or a completion without write that clears the same bit can land in one cycle. The bench provokes this by issuing on one unit and granting the same register on another. In that cycle it also clears a second register from a third unit. After the edge the shared bit must read one and the second bit must read zero. The bench also checks that the write-after-write output stays low in an instruction's own issue cycle and rises one cycle later.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef enum logic {
    SEL_BINARY = 1'b0,
    SEL_ONEHOT = 1'b1
  } sel_enc_e;
endpackage

// File: rtl/hzd_sel_dec.sv
module hzd_sel_dec
  import hzd_pkg::*;
#(
  parameter int       NUM_REGS = 32,
  parameter sel_enc_e SEL_ENC  = SEL_BINARY,
  parameter int       SEL_W    = 5
) (
  input  logic [SEL_W-1:0]    sel_i,
  input  logic                en_i,
  output logic [NUM_REGS-1:0] mask_o
);
  if (SEL_ENC == SEL_ONEHOT) begin : g_onehot
    assign mask_o = en_i ? sel_i : '0;
  end else begin : g_binary
    localparam logic [NUM_REGS-1:0] ONE = {{(NUM_REGS-1){1'b0}}, 1'b1};
    assign mask_o = en_i ? (ONE << sel_i) : '0;
  end
endmodule

// File: rtl/hzd_unit.sv
module hzd_unit
  import hzd_pkg::*;
#(
  parameter int       NUM_REGS = 32,
  parameter int       NUM_SRC  = 2,
  parameter sel_enc_e SEL_ENC  = SEL_BINARY,
  parameter int       SEL_W    = 5
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            issue_i,
  input  logic                            pick_i,
  input  logic                            wflag_i,
  input  logic                            busy_i,
  input  logic                            done_i,
  input  logic                            wok_i,
  input  logic                            wgnt_i,
  input  logic [SEL_W-1:0]                dst_sel_i,
  input  logic [SEL_W-1:0]                wsel_i,
  input  logic [NUM_SRC-1:0]              src_vld_i,
  input  logic [NUM_SRC-1:0][SEL_W-1:0]   src_sel_i,
  input  logic [NUM_REGS-1:0]             vec_i,
  output logic [NUM_REGS-1:0]             set_o,
  output logic [NUM_REGS-1:0]             clr_o,
  output logic                            raw_o,
  output logic                            waw_o
);
  logic                            wfl_q;
  logic                            chk_off_q;
  logic [SEL_W-1:0]                dst_q;
  logic                            take;
  logic                            nowr_en;
  logic [NUM_REGS-1:0]             dst_oh;
  logic [NUM_REGS-1:0]             wr_oh;
  logic [NUM_REGS-1:0]             nowr_oh;
  logic [NUM_SRC-1:0][NUM_REGS-1:0] src_oh;
  logic [NUM_REGS-1:0]             rd_mask;

  assign take    = issue_i & pick_i;
  assign nowr_en = done_i & wfl_q & ~wok_i;

  hzd_sel_dec #(.NUM_REGS(NUM_REGS), .SEL_ENC(SEL_ENC), .SEL_W(SEL_W)) u_dst (
    .sel_i(dst_sel_i), .en_i(1'b1), .mask_o(dst_oh));
  hzd_sel_dec #(.NUM_REGS(NUM_REGS), .SEL_ENC(SEL_ENC), .SEL_W(SEL_W)) u_wr (
    .sel_i(wsel_i), .en_i(wgnt_i), .mask_o(wr_oh));
  hzd_sel_dec #(.NUM_REGS(NUM_REGS), .SEL_ENC(SEL_ENC), .SEL_W(SEL_W)) u_nowr (
    .sel_i(dst_q), .en_i(nowr_en), .mask_o(nowr_oh));

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    hzd_sel_dec #(.NUM_REGS(NUM_REGS), .SEL_ENC(SEL_ENC), .SEL_W(SEL_W)) u_src (
      .sel_i(src_sel_i[s]), .en_i(src_vld_i[s]), .mask_o(src_oh[s]));
  end

  always_comb begin
    rd_mask = '0;
    if (pick_i && !chk_off_q) begin
      for (int s = 0; s < NUM_SRC; s++) rd_mask |= src_oh[s];
    end
  end

  assign set_o = (take & wflag_i) ? dst_oh : '0;
  assign clr_o = wr_oh | nowr_oh;
  assign raw_o = |(vec_i & rd_mask);
  assign waw_o = pick_i & wflag_i & (|(vec_i & dst_oh));

  // write flag and destination captured at issue, flag dropped once idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wfl_q <= 1'b0;
      dst_q <= '0;
    end else if (take) begin
      wfl_q <= wflag_i;
      dst_q <= dst_sel_i;
    end else if (!busy_i) begin
      wfl_q <= 1'b0;
    end
  end

  // source checking stops after a clean busy cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     chk_off_q <= 1'b0;
    else if (!busy_i) chk_off_q <= 1'b0;
    else if (!raw_o)  chk_off_q <= 1'b1;
  end
endmodule

// File: rtl/hzd_vec.sv
module hzd_vec #(
  parameter int NUM_REGS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_REGS-1:0] set_i,
  input  logic [NUM_REGS-1:0] clr_i,
  output logic [NUM_REGS-1:0] vec_o
);
  logic [NUM_REGS-1:0] vec_q;

  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vec_q <= '0;
    else         vec_q <= (vec_q & ~clr_i) | set_i;
  end

  assign vec_o = vec_q;
endmodule

// File: rtl/hazard_scoreboard.sv
module hazard_scoreboard
  import hzd_pkg::*;
#(
  parameter int       NUM_REGS  = 32,
  parameter int       NUM_UNITS = 3,
  parameter int       NUM_SRC   = 2,
  parameter sel_enc_e SEL_ENC   = SEL_BINARY,
  localparam int      SEL_W     = (SEL_ENC == SEL_ONEHOT) ? NUM_REGS : $clog2(NUM_REGS)
) (
  input  logic                                         clk_i,
  input  logic                                         rst_ni,
  input  logic [NUM_UNITS-1:0]                         issue_i,
  input  logic [NUM_UNITS-1:0]                         pick_i,
  input  logic [NUM_UNITS-1:0]                         wflag_i,
  input  logic [NUM_UNITS-1:0]                         busy_i,
  input  logic [NUM_UNITS-1:0]                         done_i,
  input  logic [NUM_UNITS-1:0]                         wok_i,
  input  logic [NUM_UNITS-1:0]                         wgnt_i,
  input  logic [NUM_UNITS-1:0][SEL_W-1:0]              dst_sel_i,
  input  logic [NUM_UNITS-1:0][SEL_W-1:0]              wsel_i,
  input  logic [NUM_UNITS-1:0][NUM_SRC-1:0]            src_vld_i,
  input  logic [NUM_UNITS-1:0][NUM_SRC-1:0][SEL_W-1:0] src_sel_i,
  output logic [NUM_REGS-1:0]                          pend_o,
  output logic [NUM_UNITS-1:0]                         raw_unit_o,
  output logic                                         raw_hzd_o,
  output logic                                         waw_hzd_o
);
  logic [NUM_UNITS-1:0][NUM_REGS-1:0] set_u;
  logic [NUM_UNITS-1:0][NUM_REGS-1:0] clr_u;
  logic [NUM_UNITS-1:0]               waw_u;
  logic [NUM_REGS-1:0]                set_all;
  logic [NUM_REGS-1:0]                clr_all;
  logic [NUM_REGS-1:0]                vec;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    hzd_unit #(
      .NUM_REGS(NUM_REGS), .NUM_SRC(NUM_SRC), .SEL_ENC(SEL_ENC), .SEL_W(SEL_W)
    ) u_unit (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .issue_i  (issue_i[u]),
      .pick_i   (pick_i[u]),
      .wflag_i  (wflag_i[u]),
      .busy_i   (busy_i[u]),
      .done_i   (done_i[u]),
      .wok_i    (wok_i[u]),
      .wgnt_i   (wgnt_i[u]),
      .dst_sel_i(dst_sel_i[u]),
      .wsel_i   (wsel_i[u]),
      .src_vld_i(src_vld_i[u]),
      .src_sel_i(src_sel_i[u]),
      .vec_i    (vec),
      .set_o    (set_u[u]),
      .clr_o    (clr_u[u]),
      .raw_o    (raw_unit_o[u]),
      .waw_o    (waw_u[u])
    );
  end

  always_comb begin
    set_all = '0;
    clr_all = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      set_all |= set_u[u];
      clr_all |= clr_u[u];
    end
  end

  hzd_vec #(.NUM_REGS(NUM_REGS)) u_vec (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (set_all),
    .clr_i (clr_all),
    .vec_o (vec)
  );

  assign pend_o    = vec;
  assign raw_hzd_o = |raw_unit_o;
  assign waw_hzd_o = |waw_u;
endmodule

// File: rtl/hzd_checker.sv
module hzd_checker #(
  parameter int NUM_REGS  = 32,
  parameter int NUM_UNITS = 3
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_REGS-1:0]  pend_o,
  input logic [NUM_REGS-1:0]  set_all,
  input logic [NUM_REGS-1:0]  clr_all,
  input logic [NUM_UNITS-1:0] raw_unit_o,
  input logic                 raw_hzd_o,
  input logic                 waw_hzd_o
);
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(set_all) & ~pend_o) == '0)); // R7
  AST_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_o & $past(clr_all & ~set_all)) == '0)); // R4
  AST_NO_STRAY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_o & ~$past(pend_o) & ~$past(set_all)) == '0)); // R2
  AST_RAW_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_hzd_o || (raw_unit_o != '0)) |-> (pend_o != '0)); // R9
  AST_WAW_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    waw_hzd_o |-> (pend_o != '0)); // R11
endmodule

bind hazard_scoreboard hzd_checker #(.NUM_REGS(NUM_REGS), .NUM_UNITS(NUM_UNITS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pend_o    (pend_o),
  .set_all   (set_all),
  .clr_all   (clr_all),
  .raw_unit_o(raw_unit_o),
  .raw_hzd_o (raw_hzd_o),
  .waw_hzd_o (waw_hzd_o)
);

// File: tb/hazard_scoreboard_test.sv
module hazard_scoreboard_test;
  import hzd_pkg::*;
  localparam int NR = 32, NU = 3, NS = 2, SW = 5;
  localparam int OP_SET = 0, OP_CLR = 1, OP_RAW = 2, OP_WAW = 3;
  // {op[9:8], unit[7:6], reg[5:1], expected[0]}
  localparam logic [9:0] TBL [13] = '{
    {2'd0, 2'd0, 5'd3,  1'b1}, {2'd2, 2'd1, 5'd3,  1'b1}, {2'd2, 2'd1, 5'd4,  1'b0},
    {2'd3, 2'd2, 5'd3,  1'b1}, {2'd3, 2'd2, 5'd5,  1'b0}, {2'd0, 2'd1, 5'd31, 1'b1},
    {2'd1, 2'd2, 5'd3,  1'b0}, {2'd2, 2'd0, 5'd3,  1'b0}, {2'd2, 2'd0, 5'd31, 1'b1},
    {2'd1, 2'd0, 5'd31, 1'b0}, {2'd3, 2'd1, 5'd31, 1'b0}, {2'd0, 2'd2, 5'd0,  1'b1},
    {2'd1, 2'd1, 5'd0,  1'b0}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic [NU-1:0] issue, pick, wflag, busy, done, wok, wgnt;
  logic [NU-1:0][SW-1:0] dst_sel, wsel;
  logic [NU-1:0][NS-1:0] src_vld;
  logic [NU-1:0][NS-1:0][SW-1:0] src_sel;
  logic [NR-1:0] pend;
  logic [NU-1:0] raw_unit;
  logic raw_hzd, waw_hzd;

  logic [0:0] o_issue, o_pick, o_wflag, o_busy, o_done, o_wok, o_wgnt;
  logic [0:0][7:0] o_dst, o_wsel;
  logic [0:0][0:0] o_svld;
  logic [0:0][0:0][7:0] o_ssel;
  logic [7:0] o_pend;
  logic [0:0] o_raw_unit;
  logic o_raw, o_waw;

  int total = 0, bad = 0;

  hazard_scoreboard #(.NUM_REGS(NR), .NUM_UNITS(NU), .NUM_SRC(NS)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .issue_i(issue), .pick_i(pick), .wflag_i(wflag),
    .busy_i(busy), .done_i(done), .wok_i(wok), .wgnt_i(wgnt), .dst_sel_i(dst_sel),
    .wsel_i(wsel), .src_vld_i(src_vld), .src_sel_i(src_sel), .pend_o(pend),
    .raw_unit_o(raw_unit), .raw_hzd_o(raw_hzd), .waw_hzd_o(waw_hzd));

  hazard_scoreboard #(.NUM_REGS(8), .NUM_UNITS(1), .NUM_SRC(1), .SEL_ENC(SEL_ONEHOT)) uut_oh (
    .clk_i(clk), .rst_ni(rst_ni), .issue_i(o_issue), .pick_i(o_pick), .wflag_i(o_wflag),
    .busy_i(o_busy), .done_i(o_done), .wok_i(o_wok), .wgnt_i(o_wgnt), .dst_sel_i(o_dst),
    .wsel_i(o_wsel), .src_vld_i(o_svld), .src_sel_i(o_ssel), .pend_o(o_pend),
    .raw_unit_o(o_raw_unit), .raw_hzd_o(o_raw), .waw_hzd_o(o_waw));

  task automatic idle();
    issue = '0; pick = '0; wflag = '0; busy = '0; done = '0; wok = '0; wgnt = '0;
    dst_sel = '0; wsel = '0; src_vld = '0; src_sel = '0;
    o_issue = '0; o_pick = '0; o_wflag = '0; o_busy = '0; o_done = '0; o_wok = '0;
    o_wgnt = '0; o_dst = '0; o_wsel = '0; o_svld = '0; o_ssel = '0;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    #1;
    chk("R1 pend", pend, 0);
    chk("R1 raw", raw_hzd, 0);
    chk("R1 waw", waw_hzd, 0);

    for (int i = 0; i < 13; i++) begin
      automatic int op = TBL[i][9:8];
      automatic int u = TBL[i][7:6];
      automatic logic [4:0] r = TBL[i][5:1];
      automatic logic e = TBL[i][0];
      idle();
      case (op)
        OP_SET: begin
          issue[u] = 1; pick[u] = 1; wflag[u] = 1; dst_sel[u] = r;
          step(); idle(); chk("R2 table set", pend[r], e);
        end
        OP_CLR: begin
          wgnt[u] = 1; wsel[u] = r;
          step(); idle(); chk("R4 table clear", pend[r], e);
        end
        OP_RAW: begin
          pick[u] = 1; src_vld[u][0] = 1; src_sel[u][0] = r;
          #1 chk("R9 table raw", raw_hzd, e);
          step();
        end
        default: begin
          pick[u] = 1; wflag[u] = 1; dst_sel[u] = r;
          #1 chk("R11 table waw", waw_hzd, e);
          step();
        end
      endcase
    end
    idle();

    // R2 missing qualifiers
    issue[0] = 1; pick[0] = 1; dst_sel[0] = 6; step(); idle();
    chk("R2 no wflag", pend[6], 0);
    issue[0] = 1; wflag[0] = 1; dst_sel[0] = 6; step(); idle();
    chk("R2 no pick", pend[6], 0);

    // R3 own set invisible in issue cycle
    issue[1] = 1; pick[1] = 1; wflag[1] = 1; dst_sel[1] = 7;
    #1 chk("R3 same cycle", waw_hzd, 0);
    step(); issue[1] = 0;
    #1 chk("R3 next cycle", waw_hzd, 1);
    step(); idle(); wgnt[2] = 1; wsel[2] = 7; step(); idle();
    chk("R4 clear 7", pend[7], 0);

    // R8 multi-unit set, R7 set beats clear
    issue[1] = 1; pick[1] = 1; wflag[1] = 1; dst_sel[1] = 10;
    issue[2] = 1; pick[2] = 1; wflag[2] = 1; dst_sel[2] = 11;
    step(); idle();
    chk("R8 both set", pend[11:10], 2'b11);
    issue[0] = 1; pick[0] = 1; wflag[0] = 1; dst_sel[0] = 10;
    wgnt[1] = 1; wsel[1] = 10; wgnt[2] = 1; wsel[2] = 11;
    step(); idle();
    chk("R7 set wins", pend[10], 1);
    chk("R8 other cleared", pend[11], 0);
    wgnt[0] = 1; wsel[0] = 10; step(); idle();
    chk("R4 all clear", pend, 0);

    // R5 completion without write
    issue[0] = 1; pick[0] = 1; wflag[0] = 1; dst_sel[0] = 12; busy[0] = 1; step();
    issue[0] = 0; pick[0] = 0; wflag[0] = 0;
    chk("R5 set 12", pend[12], 1);
    done[0] = 1; step(); idle();
    chk("R5 no-write clear", pend[12], 0);
    issue[0] = 1; pick[0] = 1; wflag[0] = 1; dst_sel[0] = 13; busy[0] = 1; step();
    issue[0] = 0; pick[0] = 0; wflag[0] = 0; done[0] = 1; wok[0] = 1; step(); idle();
    chk("R5 valid result kept", pend[13], 1);
    wgnt[0] = 1; wsel[0] = 13; step(); idle();

    // R6 latched flag drops when idle
    issue[0] = 1; pick[0] = 1; wflag[0] = 1; dst_sel[0] = 14; busy[0] = 1; step(); idle();
    step();
    done[0] = 1; step(); idle();
    chk("R6 stale done", pend[14], 1);
    wgnt[0] = 1; wsel[0] = 14; step(); idle();

    // R10 check stops after clean busy cycle
    issue[2] = 1; pick[2] = 1; wflag[2] = 1; dst_sel[2] = 20; step(); idle();
    pick[0] = 1; busy[0] = 1; src_vld[0][0] = 1; src_sel[0][0] = 21;
    #1 chk("R9 clean src", raw_hzd, 0);
    step(); src_sel[0][0] = 20;
    #1 chk("R10 stopped", raw_unit[0], 0);
    step(); idle(); step();
    pick[0] = 1; src_vld[0][1] = 1; src_sel[0][1] = 20;
    #1 chk("R10 resumed", raw_hzd, 1);
    src_vld[0][1] = 0;
    #1 chk("R9 invalid src", raw_hzd, 0);
    step(); idle();
    pick[1] = 1; busy[1] = 1; src_vld[1][0] = 1; src_sel[1][0] = 20;
    #1 chk("R10 hazard seen", raw_unit[1], 1);
    step();
    chk("R10 hazard held", raw_unit[1], 1);
    idle(); step();
    wgnt[1] = 1; wsel[1] = 20; step(); idle();
    chk("R4 clear 20", pend, 0);

    // R12 one-hot selects
    o_issue = 1; o_pick = 1; o_wflag = 1; o_dst[0] = 8'h24; step(); idle();
    chk("R12 onehot set", o_pend, 8'h24);
    o_pick = 1; o_svld = 1; o_ssel[0][0] = 8'h04;
    #1 chk("R12 onehot raw", o_raw, 1);
    step(); idle();
    o_wgnt = 1; o_wsel[0] = 8'h20; step(); idle();
    chk("R12 onehot clear", o_pend, 8'h04);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule